// File: doc/BRIEF.md
# BCD Calendar Timekeeper

This block keeps wall-clock time and calendar date as packed BCD registers. A fast enable, `sub_tick`, feeds a prescaler. Every `SUB_PER_SEC` sub-ticks it issues a one-second step. That step ripples through seconds, minutes and hours, then day of month, weekday, month and a two-digit year covering 2000 to 2099. The day-of-month limit follows the month length, and February gets a 29th day when the year value is a multiple of four.

Software reaches the fields through one request channel and one read-response channel. The hour is always counted internally in 24-hour form. A mode bit in the control register picks how the hour is shown and how a written hour is interpreted:
- In 24-hour mode the hour is plain BCD.
- In 12-hour mode it is BCD 1 to 12 with a PM flag in bit 5.

Changing the mode alters only this view. The count itself does not move.

Both channels use valid/ready. A request (read or write) is taken in any cycle where `req_valid` and `req_ready` are both high. `req_ready` is low only while a read response is held and `rsp_ready` is low, so a stalled consumer stalls new requests as well. A read's data appears in the cycle after acceptance and stays fixed until it is taken. Writes produce no response.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the fields read: seconds 0x00, minutes 0x00, hour 0x12 (12-hour mode, midnight), weekday 0x01, day 0x01, month 0x01, year 0x00, control 0x00. Any address from 7 to 14 reads 0x00.
- R2: Each `SUB_PER_SEC`-th sub-tick advances seconds by one in BCD. Seconds 0x59 wraps to 0x00 and carries into minutes, and minutes 0x59 wraps to 0x00 and carries into the hour. With no step and no write, no field changes.
- R3: The step from hour 0x23, minute 0x59, second 0x59 gives 00:00:00, advances the day, and advances the weekday cyclically 1..7 (7 becomes 1).
- R4: The day wraps to 0x01 after 0x31 in months 1,3,5,7,8,10,12, after 0x30 in months 4,6,9,11, and in month 2 after 0x29 if the year is divisible by 4 (else after 0x28). On a day wrap the month advances, 0x12 wraps to 0x01, and the year advances with 0x99 wrapping to 0x00.
- R5: With control bit 5 clear (12-hour mode), an internal hour h reads as follows: h=0 reads 0x12; 1 to 11 read as BCD h; h=12 reads 0x32; 13 to 23 read 0x20 | BCD(h-12).
- R6: With control bit 5 set (24-hour mode) the hour reads as BCD 0x00..0x23. Toggling the bit re-encodes the hour read at once and leaves the count unchanged.
- R7: In 12-hour mode a hour write takes BCD bits 4:0 plus PM flag bit 5. 0x12 stores hour 0, 0x32 stores hour 12, and PM adds 12 to 1..11.
- R8: Write masks, by field address:
  - seconds (0) and minutes (1) keep bits 6:0;
  - the 24-hour hour (2) keeps bits 5:0;
  - weekday (3) keeps bits 2:0;
  - day (4) keeps bits 5:0;
  - month (5) keeps bits 4:0;
  - year (6) keeps all 8 bits;
  - control (15) keeps only bit 5.

  Writes to addresses 7 to 14 change nothing.
- R9: A seconds write clears the prescaler, so the next step comes after exactly `SUB_PER_SEC` further sub-ticks. No step occurs in the write's own cycle.
- R10: When a write lands in the cycle of a step, the written field takes the written value and the other fields advance normally. A read accepted in that cycle returns the value before the step.
- R11: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted read raises `rsp_valid` in the next cycle. `rsp_data` stays stable while `rsp_valid && !rsp_ready`. Writes raise no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_tick | input | 1 | Prescaler enable, one pulse per sub-second unit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Field address (0..6 time fields, 15 control) |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 8 | Read data |

## Verification
The step of the prescaler and a field write can fall in the same cycle. So can the step and a read. The bench provokes this by raising the last sub-tick of a second together with a minutes write, then with a seconds write, then with a read. It then judges the result from the fields read afterwards: the written field holds its written value, the neighbours have stepped, and the read returned the pre-step value. A seconds write on the step edge must swallow that step and restart a full second.

// File: rtl/tk_pkg.sv
`timescale 1ns/1ps
package tk_pkg;
  localparam int unsigned TK_AW    = 4;
  localparam int unsigned TK_DW    = 8;
  localparam int unsigned MODE_BIT = 5;

  localparam logic [TK_AW-1:0] RA_SEC  = 4'd0;
  localparam logic [TK_AW-1:0] RA_MIN  = 4'd1;
  localparam logic [TK_AW-1:0] RA_HOUR = 4'd2;
  localparam logic [TK_AW-1:0] RA_WDAY = 4'd3;
  localparam logic [TK_AW-1:0] RA_MDAY = 4'd4;
  localparam logic [TK_AW-1:0] RA_MON  = 4'd5;
  localparam logic [TK_AW-1:0] RA_YEAR = 4'd6;
  localparam logic [TK_AW-1:0] RA_CTRL = 4'd15;

  typedef logic [TK_DW-1:0] bcd8_t;

  typedef struct packed {
    bcd8_t secs;
    bcd8_t mins;
    bcd8_t hrs;   // always 24-hour BCD
    bcd8_t wday;
    bcd8_t mday;
    bcd8_t mon;
    bcd8_t yr;
  } tk_time_t;

  function automatic bcd8_t bcd_inc(bcd8_t v);
    bcd8_t r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  function automatic logic [7:0] bcd_to_bin(bcd8_t v);
    return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
  endfunction

  function automatic bcd8_t bin_to_bcd(logic [7:0] b);
    logic [7:0] t;
    logic [7:0] u;
    t = b / 8'd10;
    u = b - t * 8'd10;
    return {t[3:0], u[3:0]};
  endfunction

  // last valid day of a month, in BCD
  function automatic bcd8_t month_last(bcd8_t mon, bcd8_t yr);
    logic [7:0] ybin;
    bcd8_t      r;
    ybin = bcd_to_bin(yr);
    case (mon)
      8'h02:                      r = (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tk_prescaler.sv
`timescale 1ns/1ps
module tk_prescaler #(
  parameter int unsigned SUB_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sub_tick,
  input  logic clear,
  output logic sec_pulse
);
  localparam int unsigned CW = (SUB_PER_SEC > 1) ? $clog2(SUB_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SUB_PER_SEC - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last   = (cnt_q == LAST);
  assign sec_pulse = sub_tick && at_last && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear)    cnt_q <= '0;
    else if (sub_tick) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tk_hour_codec.sv
`timescale 1ns/1ps
module tk_hour_codec
  import tk_pkg::*;
(
  input  bcd8_t      hr24,
  input  logic       mode24,
  input  logic [5:0] wdata,
  output bcd8_t      hr_view,
  output bcd8_t      hr_load
);
  logic [7:0] h_bin;
  logic [7:0] w_bin;
  logic [7:0] w_sum;

  assign h_bin = bcd_to_bin(hr24);
  assign w_bin = bcd_to_bin({3'b000, wdata[4:0]});

  // read side: 24-hour count to the selected view
  always_comb begin
    if (mode24)               hr_view = hr24;
    else if (h_bin == 8'd0)   hr_view = 8'h12;
    else if (h_bin < 8'd12)   hr_view = hr24;
    else if (h_bin == 8'd12)  hr_view = 8'h32;
    else                      hr_view = 8'h20 | bin_to_bcd(h_bin - 8'd12);
  end

  // write side: selected view to 24-hour count
  always_comb begin
    w_sum = w_bin + (wdata[5] ? 8'd12 : 8'd0);
    if (w_bin == 8'd12) w_sum = w_sum - 8'd12;
    if (mode24) hr_load = {2'b00, wdata};
    else        hr_load = bin_to_bcd(w_sum);
  end
endmodule

// File: rtl/tk_calendar.sv
`timescale 1ns/1ps
module tk_calendar
  import tk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_pulse,
  input  logic             wr_en,
  input  logic [TK_AW-1:0] wr_addr,
  input  bcd8_t            wr_data,
  input  bcd8_t            hr_load,
  output tk_time_t         time_q,
  output logic             mode24
);
  tk_time_t cur_q;
  tk_time_t adv;
  tk_time_t nxt;
  bcd8_t    last_day;
  logic     mode_q;

  assign last_day = month_last(cur_q.mon, cur_q.yr);

  // carry chain for one second step
  always_comb begin
    adv = cur_q;
    if (sec_pulse) begin
      if (cur_q.secs >= 8'h59) begin
        adv.secs = 8'h00;
        if (cur_q.mins >= 8'h59) begin
          adv.mins = 8'h00;
          if (cur_q.hrs >= 8'h23) begin
            adv.hrs = 8'h00;
            if (cur_q.wday[2:0] == 3'd7 || cur_q.wday[2:0] == 3'd0) adv.wday = 8'h01;
            else adv.wday = {5'b0, cur_q.wday[2:0] + 3'd1};
            if (cur_q.mday >= last_day) begin
              adv.mday = 8'h01;
              if (cur_q.mon >= 8'h12) begin
                adv.mon = 8'h01;
                adv.yr  = (cur_q.yr >= 8'h99) ? 8'h00 : bcd_inc(cur_q.yr);
              end else begin
                adv.mon = bcd_inc(cur_q.mon);
              end
            end else begin
              adv.mday = bcd_inc(cur_q.mday);
            end
          end else begin
            adv.hrs = bcd_inc(cur_q.hrs);
          end
        end else begin
          adv.mins = bcd_inc(cur_q.mins);
        end
      end else begin
        adv.secs = bcd_inc(cur_q.secs);
      end
    end
  end

  // a write overrides only its own field
  always_comb begin
    nxt = adv;
    if (wr_en) begin
      case (wr_addr)
        RA_SEC:  nxt.secs = {1'b0, wr_data[6:0]};
        RA_MIN:  nxt.mins = {1'b0, wr_data[6:0]};
        RA_HOUR: nxt.hrs  = hr_load;
        RA_WDAY: nxt.wday = {5'b0, wr_data[2:0]};
        RA_MDAY: nxt.mday = {2'b0, wr_data[5:0]};
        RA_MON:  nxt.mon  = {3'b0, wr_data[4:0]};
        RA_YEAR: nxt.yr   = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '{secs: 8'h00, mins: 8'h00, hrs: 8'h00, wday: 8'h01,
                  mday: 8'h01, mon: 8'h01, yr: 8'h00};
      mode_q <= 1'b0;
    end else begin
      cur_q <= nxt;
      if (wr_en && wr_addr == RA_CTRL) mode_q <= wr_data[MODE_BIT];
    end
  end

  assign time_q = cur_q;
  assign mode24 = mode_q;
endmodule

// File: rtl/tk_reg_port.sv
`timescale 1ns/1ps
module tk_reg_port
  import tk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [TK_AW-1:0] req_addr,
  input  bcd8_t            req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output bcd8_t            rsp_data,
  input  tk_time_t         time_q,
  input  bcd8_t            hr_view,
  input  logic             mode24,
  output logic             wr_en,
  output logic [TK_AW-1:0] wr_addr,
  output bcd8_t            wr_data
);
  logic  rsp_valid_q;
  bcd8_t rsp_data_q;
  bcd8_t rd_mux;
  logic  accept;
  logic  rd_go;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign rd_go     = accept && !req_write;
  assign wr_en     = accept && req_write;
  assign wr_addr   = req_addr;
  assign wr_data   = req_wdata;

  always_comb begin
    rd_mux = '0;
    case (req_addr)
      RA_SEC:  rd_mux = time_q.secs;
      RA_MIN:  rd_mux = time_q.mins;
      RA_HOUR: rd_mux = hr_view;
      RA_WDAY: rd_mux = time_q.wday;
      RA_MDAY: rd_mux = time_q.mday;
      RA_MON:  rd_mux = time_q.mon;
      RA_YEAR: rd_mux = time_q.yr;
      RA_CTRL: rd_mux[MODE_BIT] = mode24;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (rd_go) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/bcd_timekeeper.sv
`timescale 1ns/1ps
module bcd_timekeeper
  import tk_pkg::*;
#(
  parameter int unsigned SUB_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sub_tick,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic [3:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data
);
  logic             sec_pulse;
  logic             wr_en;
  logic [TK_AW-1:0] wr_addr;
  bcd8_t            wr_data;
  tk_time_t         time_q;
  logic             mode24;
  bcd8_t            hr_view;
  bcd8_t            hr_load;
  logic             sec_wr;

  assign sec_wr = wr_en && (wr_addr == RA_SEC);

  tk_prescaler #(.SUB_PER_SEC(SUB_PER_SEC)) u_presc (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .clear(sec_wr),
    .sec_pulse(sec_pulse)
  );

  tk_hour_codec u_codec (
    .hr24(time_q.hrs), .mode24(mode24), .wdata(wr_data[5:0]),
    .hr_view(hr_view), .hr_load(hr_load)
  );

  tk_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .hr_load(hr_load),
    .time_q(time_q), .mode24(mode24)
  );

  tk_reg_port u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .time_q(time_q), .hr_view(hr_view), .mode24(mode24),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );
endmodule

// File: rtl/bcd_timekeeper_chk.sv
`timescale 1ns/1ps
module bcd_timekeeper_chk
  import tk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [7:0]       rsp_data,
  input logic             sec_pulse,
  input logic             wr_en,
  input logic [TK_AW-1:0] wr_addr,
  input tk_time_t         time_q
);
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  assert_stall_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  assert_read_answers_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_valid);

  assert_sec_write_swallows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == RA_SEC |-> !sec_pulse);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_pulse && !wr_en |=> $stable(time_q));

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse && !wr_en && time_q.secs == 8'h59 |=> time_q.secs == 8'h00);

  assert_wday_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse && !wr_en && time_q.hrs == 8'h23 && time_q.mins == 8'h59 &&
    time_q.secs == 8'h59 && time_q.wday == 8'h07 |=> time_q.wday == 8'h01);

  assert_mode_keeps_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == RA_CTRL && !sec_pulse |=> $stable(time_q));
endmodule

bind bcd_timekeeper bcd_timekeeper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .sec_pulse(sec_pulse), .wr_en(wr_en),
  .wr_addr(wr_addr), .time_q(time_q)
);

// File: tb/tb_bcd_timekeeper.sv
`timescale 1ns/1ps
module tb_bcd_timekeeper;
  localparam int SPS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sub_tick = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  bcd_timekeeper #(.SUB_PER_SEC(SPS)) dut (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_data;
  endtask

  task automatic expect_reg(input string tag, input logic [3:0] a, input logic [7:0] e);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, e);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sub_tick = 1'b1;
      @(negedge clk); sub_tick = 1'b0;
    end
  endtask

  // write issued in the same cycle as a sub-tick
  task automatic wr_on_tick(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    sub_tick = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    sub_tick = 1'b0; req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic set_hms(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(4'd2, h); wr(4'd1, m); wr(4'd0, s);
  endtask

  task automatic t_reset;
    chk("R11 ready after reset", {7'b0, req_ready}, 8'h01);
    chk("R11 no rsp after reset", {7'b0, rsp_valid}, 8'h00);
    expect_reg("R1 sec", 4'd0, 8'h00);
    expect_reg("R1 min", 4'd1, 8'h00);
    expect_reg("R1 hour 12AM", 4'd2, 8'h12);
    expect_reg("R1 wday", 4'd3, 8'h01);
    expect_reg("R1 mday", 4'd4, 8'h01);
    expect_reg("R1 month", 4'd5, 8'h01);
    expect_reg("R1 year", 4'd6, 8'h00);
    expect_reg("R1 ctrl", 4'd15, 8'h00);
    expect_reg("R1 unused addr", 4'd9, 8'h00);
  endtask

  task automatic t_seconds;
    wr(4'd15, 8'h20);
    set_hms(8'h10, 8'h59, 8'h58);
    ticks(SPS - 1);
    expect_reg("R9 no step before full second", 4'd0, 8'h58);
    ticks(1);
    expect_reg("R2 sec step", 4'd0, 8'h59);
    ticks(SPS);
    expect_reg("R2 sec wrap", 4'd0, 8'h00);
    expect_reg("R2 min wrap", 4'd1, 8'h00);
    expect_reg("R2 hour carry", 4'd2, 8'h11);
    ticks(2);
    wr(4'd0, 8'h30);
    ticks(SPS - 1);
    expect_reg("R9 prescaler cleared", 4'd0, 8'h30);
    ticks(1);
    expect_reg("R9 step after full second", 4'd0, 8'h31);
  endtask

  task automatic t_dayroll;
    wr(4'd3, 8'h07); wr(4'd4, 8'h31); wr(4'd5, 8'h12); wr(4'd6, 8'h99);
    set_hms(8'h23, 8'h59, 8'h59);
    ticks(SPS);
    expect_reg("R3 hour midnight", 4'd2, 8'h00);
    expect_reg("R3 min", 4'd1, 8'h00);
    expect_reg("R3 wday 7->1", 4'd3, 8'h01);
    expect_reg("R4 mday wrap", 4'd4, 8'h01);
    expect_reg("R4 month wrap", 4'd5, 8'h01);
    expect_reg("R4 year 99->00", 4'd6, 8'h00);
    wr(4'd3, 8'h03); wr(4'd4, 8'h15); wr(4'd5, 8'h06); wr(4'd6, 8'h10);
    set_hms(8'h23, 8'h59, 8'h59);
    ticks(SPS);
    expect_reg("R3 wday 3->4", 4'd3, 8'h04);
    expect_reg("R3 mday step", 4'd4, 8'h16);
    expect_reg("R3 month kept", 4'd5, 8'h06);
  endtask

  task automatic roll_day(input logic [7:0] yr, input logic [7:0] mon, input logic [7:0] day,
                          input logic [7:0] e_day, input logic [7:0] e_mon, input string tag);
    wr(4'd6, yr); wr(4'd5, mon); wr(4'd4, day);
    set_hms(8'h23, 8'h59, 8'h59);
    ticks(SPS);
    expect_reg({"R4 day ", tag}, 4'd4, e_day);
    expect_reg({"R4 mon ", tag}, 4'd5, e_mon);
  endtask

  task automatic t_months;
    roll_day(8'h24, 8'h02, 8'h28, 8'h29, 8'h02, "leap feb28");
    roll_day(8'h24, 8'h02, 8'h29, 8'h01, 8'h03, "leap feb29");
    roll_day(8'h23, 8'h02, 8'h28, 8'h01, 8'h03, "common feb28");
    roll_day(8'h00, 8'h02, 8'h28, 8'h29, 8'h02, "year00 feb28");
    roll_day(8'h23, 8'h04, 8'h30, 8'h01, 8'h05, "apr30");
    roll_day(8'h23, 8'h01, 8'h30, 8'h31, 8'h01, "jan30");
    roll_day(8'h19, 8'h09, 8'h09, 8'h10, 8'h09, "digit carry");
  endtask

  task automatic t_hour12_read;
    logic [7:0] h24 [6] = '{8'h00, 8'h09, 8'h11, 8'h12, 8'h13, 8'h23};
    logic [7:0] h12 [6] = '{8'h12, 8'h09, 8'h11, 8'h32, 8'h21, 8'h31};
    for (int i = 0; i < 6; i++) begin
      wr(4'd15, 8'h20);
      wr(4'd2, h24[i]);
      wr(4'd15, 8'h00);
      expect_reg("R5 12h view", 4'd2, h12[i]);
      wr(4'd15, 8'h20);
      expect_reg("R6 24h view restored", 4'd2, h24[i]);
    end
  endtask

  task automatic t_hour12_write;
    logic [7:0] w12 [6] = '{8'h12, 8'h32, 8'h21, 8'h11, 8'h31, 8'h01};
    logic [7:0] e24 [6] = '{8'h00, 8'h12, 8'h13, 8'h11, 8'h23, 8'h01};
    for (int i = 0; i < 6; i++) begin
      wr(4'd15, 8'h00);
      wr(4'd2, w12[i]);
      expect_reg("R7 12h readback", 4'd2, w12[i]);
      wr(4'd15, 8'h20);
      expect_reg("R7 stored 24h hour", 4'd2, e24[i]);
    end
  endtask

  task automatic t_masking;
    wr(4'd15, 8'h20);
    wr(4'd0, 8'hFF); expect_reg("R8 sec mask", 4'd0, 8'h7F);
    wr(4'd1, 8'hA5); expect_reg("R8 min mask", 4'd1, 8'h25);
    wr(4'd2, 8'hD3); expect_reg("R8 hour mask", 4'd2, 8'h13);
    wr(4'd3, 8'hFE); expect_reg("R8 wday mask", 4'd3, 8'h06);
    wr(4'd4, 8'hC7); expect_reg("R8 mday mask", 4'd4, 8'h07);
    wr(4'd5, 8'hF1); expect_reg("R8 month mask", 4'd5, 8'h11);
    wr(4'd6, 8'h85); expect_reg("R8 year full", 4'd6, 8'h85);
    wr(4'd15, 8'hFF); expect_reg("R8 ctrl keeps bit5", 4'd15, 8'h20);
    wr(4'd9, 8'h55);
    expect_reg("R8 unused addr reads 0", 4'd9, 8'h00);
    expect_reg("R8 unused write leaves year", 4'd6, 8'h85);
    expect_reg("R8 unused write leaves sec", 4'd0, 8'h7F);
    wr(4'd15, 8'hDF); expect_reg("R8 ctrl bit5 clear", 4'd15, 8'h00);
    wr(4'd15, 8'h20);
  endtask

  task automatic t_coincide;
    logic [7:0] d;
    set_hms(8'h05, 8'h10, 8'h59);
    ticks(SPS - 1);
    wr_on_tick(4'd1, 8'h30);
    expect_reg("R10 sec stepped", 4'd0, 8'h00);
    expect_reg("R10 written min wins", 4'd1, 8'h30);
    expect_reg("R10 hour untouched", 4'd2, 8'h05);
    ticks(SPS - 1);
    wr_on_tick(4'd0, 8'h20);
    expect_reg("R10 sec write on step", 4'd0, 8'h20);
    expect_reg("R10 min after sec write", 4'd1, 8'h30);
    ticks(SPS - 1);
    expect_reg("R9 swallowed step restarts", 4'd0, 8'h20);
    ticks(1);
    expect_reg("R9 next step", 4'd0, 8'h21);
    ticks(SPS - 1);
    @(negedge clk);
    sub_tick = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd0;
    @(negedge clk);
    sub_tick = 1'b0; req_valid = 1'b0;
    d = rsp_data;
    chk("R10 read on step sees old value", d, 8'h21);
    expect_reg("R10 value after step", 4'd0, 8'h22);
  endtask

  task automatic t_handshake;
    logic [7:0] held;
    wr(4'd6, 8'h47);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd6;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 rsp valid after read", {7'b0, rsp_valid}, 8'h01);
    chk("R11 ready low while stalled", {7'b0, req_ready}, 8'h00);
    chk("R11 read data", rsp_data, 8'h47);
    held = rsp_data;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 rsp held", {7'b0, rsp_valid}, 8'h01);
      chk("R11 data stable", rsp_data, held);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 rsp drained", {7'b0, rsp_valid}, 8'h00);
    wr(4'd4, 8'h12);
    chk("R11 write gives no rsp", {7'b0, rsp_valid}, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_seconds();
    t_dayroll();
    t_months();
    t_hour12_read();
    t_hour12_write();
    t_masking();
    t_coincide();
    t_handshake();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule